// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block sits between an external dual-modulus prescaler and a phase detector in a frequency synthesizer loop. It is clocked by the prescaler output `fin` and tells the prescaler, through `mc`, whether to divide by the high modulus (P+1) or the low modulus (P). Two down-counters run side by side. The cycle counter fixes the length of one output cycle at N prescaler periods. The swallow counter keeps the prescaler on the high modulus for the first A of those periods. The total division from the prescaler input to `fv` is therefore N·P + A, provided that A does not exceed N.

The programmed values `n_val` and `a_val` come from holding registers outside the block. The block captures them only on the `fin` edge that starts a cycle, so software can rewrite them at any time without corrupting the cycle in progress. `fv` is a one-period pulse that marks the start of each cycle and goes to the phase detector as its variable-frequency input.

Top module: `pswallow_divider`

## Requirements
- R1: While `rst_n` is low, `mc` and `fv` are both 0. The first rising `fin` edge after reset is released starts a new cycle with the values present on `n_val` and `a_val`.
- R2: A cycle lasts N `fin` periods. `fv` is 1 during the first period of each cycle and 0 during the other N−1 periods.
- R3: When 0 < A < N, `mc` is 1 (high modulus, P+1) during the first A periods of the cycle.
- R4: When 0 < A < N, `mc` is 0 (low modulus, P) during the last N−A periods of the cycle. Once it has fallen, it does not rise again before the next cycle starts.
- R5: `n_val` and `a_val` are sampled only on the `fin` edge that starts a cycle. Changes at any other time do not affect `mc` or `fv` until the next cycle starts.
- R6: When A = 0, `mc` is 0 for the whole cycle.
- R7: When A ≥ N, `mc` is 1 for the whole cycle.
- R8: N = 0 and N = 1 both give a cycle of one period, so `fv` stays 1 for as long as such a value is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin | input | 1 | Prescaler output; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_val | input | 10 | Programmed cycle length N (prescaler periods per output cycle) |
| a_val | input | 7 | Programmed swallow count A (periods spent at the high modulus) |
| mc | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| fv | output | 1 | Divided output, one `fin` period wide at the start of each cycle |

## Verification
The assertions relate `fv` and `mc` to the values of `n_val` and `a_val` one edge earlier. They therefore assume that these inputs are valid and settled at every rising `fin` edge, and they make no claim about `fv` after a reset until a cycle has started. The bench changes inputs only at falling edges of `fin`, well away from the sampling edge. On the edge that starts a cycle it applies the intended programmed values. On the other edges it may apply random values, which lets it test R5 without ever presenting an unsettled value.

// File: rtl/psw_pkg.sv
package psw_pkg;

    // Default widths of the programmed values.
    localparam int unsigned PSW_N_W = 10;
    localparam int unsigned PSW_A_W = 7;

    // Modulus selection driven toward the prescaler.
    typedef enum logic {
        MOD_LOW  = 1'b0,  // divide by P
        MOD_HIGH = 1'b1   // divide by P+1
    } psw_mod_e;

endpackage

// File: rtl/psw_down_ctr.sv
// Loadable down-counter with a selectable terminal condition and underflow behaviour.
module psw_down_ctr #(
    parameter int unsigned W           = 8,
    parameter bit          SATURATE    = 1'b1,  // 1: hold at zero, 0: wrap to all ones
    parameter bit          TERM_AT_ONE = 1'b0   // 1: term_o when count <= 1, 0: when count == 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         term_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t   st_d, st_q;
    logic [W-1:0] under_val;

    generate
        if (SATURATE) begin : g_sat
            assign under_val = '0;
        end else begin : g_wrap
            assign under_val = '1;
        end

        if (TERM_AT_ONE) begin : g_term_one
            assign term_o = (st_q.cnt[W-1:1] == '0);
        end else begin : g_term_zero
            assign term_o = (st_q.cnt == '0);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.cnt = under_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pswallow_divider.sv
// Pulse-swallow divider: cycle counter plus swallow counter steering a dual-modulus prescaler.
module pswallow_divider
    import psw_pkg::*;
#(
    parameter int unsigned N_W = PSW_N_W,
    parameter int unsigned A_W = PSW_A_W
) (
    input  logic           fin,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_val,
    input  logic [A_W-1:0] a_val,
    output logic           mc,
    output logic           fv
);

    typedef struct packed {
        logic fv;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       cyc_end;   // last period of the cycle: next edge reloads
    logic       swl_done;  // swallow count exhausted
    psw_mod_e   mod_sel;

    // Cycle counter: counts N periods, terminal on its final period.
    psw_down_ctr #(
        .W           (N_W),
        .SATURATE    (1'b0),
        .TERM_AT_ONE (1'b1)
    ) u_cyc_ctr (
        .clk        (fin),
        .rst_n      (rst_n),
        .load_i     (cyc_end),
        .load_val_i (n_val),
        .term_o     (cyc_end)
    );

    // Swallow counter: reloaded with the cycle, then held at zero once spent.
    psw_down_ctr #(
        .W           (A_W),
        .SATURATE    (1'b1),
        .TERM_AT_ONE (1'b0)
    ) u_swl_ctr (
        .clk        (fin),
        .rst_n      (rst_n),
        .load_i     (cyc_end),
        .load_val_i (a_val),
        .term_o     (swl_done)
    );

    always_comb begin
        st_d    = st_q;
        st_d.fv = cyc_end;
        mod_sel = swl_done ? MOD_LOW : MOD_HIGH;
    end

    always_ff @(posedge fin or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fv = st_q.fv;
    assign mc = (mod_sel == MOD_HIGH);

endmodule

// File: rtl/psw_checker.sv
module psw_checker #(
    parameter int unsigned N_W = 10,
    parameter int unsigned A_W = 7
) (
    input logic           fin,
    input logic           rst_n,
    input logic [N_W-1:0] n_val,
    input logic [A_W-1:0] a_val,
    input logic           mc,
    input logic           fv
);

    // R3 / R6: the first period of a cycle selects high modulus exactly when A is nonzero.
    a_r3_mc_at_start: assert property (@(posedge fin) disable iff (!rst_n)
        fv |-> (mc == ($past(a_val) != '0)));

    // R4: the high modulus is entered only at the start of a cycle.
    a_r4_mc_no_rise: assert property (@(posedge fin) disable iff (!rst_n)
        $rose(mc) |-> fv);

    // R2: with N above one the pulse lasts a single period.
    a_r2_fv_single: assert property (@(posedge fin) disable iff (!rst_n)
        (fv && ($past(n_val) > 1)) |=> !fv);

    // R8: with N of zero or one every period starts a cycle.
    a_r8_fv_repeat: assert property (@(posedge fin) disable iff (!rst_n)
        (fv && ($past(n_val) <= 1)) |=> fv);

endmodule

bind pswallow_divider psw_checker #(.N_W(N_W), .A_W(A_W)) u_psw_checker (
    .fin   (fin),
    .rst_n (rst_n),
    .n_val (n_val),
    .a_val (a_val),
    .mc    (mc),
    .fv    (fv)
);

// File: tb/test_pswallow_divider.sv
module test_pswallow_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] n_val = 10'd0;
    logic [6:0] a_val = 7'd0;
    logic       mc, fv;

    int checks = 0;
    int errors = 0;

    // Reference state: position in cycle and the values captured at its start.
    int  k = 0;
    int  cur_n = 0;
    int  cur_a = 0;
    bit  started = 1'b0;
    bit  first_after_rst = 1'b0;
    bit  noisy_period = 1'b0;
    int  reloads = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pswallow_divider i_pswallow_divider (
        .fin   (clk),
        .rst_n (rst_n),
        .n_val (n_val),
        .a_val (a_val),
        .mc    (mc),
        .fv    (fv)
    );

    function automatic int eff_len(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    function automatic bit exp_mc(input int pos, input int a);
        return pos < a;
    endfunction

    function automatic bit exp_fv(input int pos);
        return pos == 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (pos %0d N=%0d A=%0d)",
                     req, act, exp, k, cur_n, cur_a);
        end
    endtask

    // Drive inputs for the coming edge, advance the reference, then check the next period.
    task automatic step(input int nn, input int aa, input bit noisy);
        bit reload;
        string tag;
        reload = !started || (k >= eff_len(cur_n) - 1);
        if (reload) begin
            n_val = 10'(nn);
            a_val = 7'(aa);
            first_after_rst = !started;
            k = 0;
            cur_n = nn;
            cur_a = aa;
            started = 1'b1;
            reloads++;
            noisy_period = 1'b0;
        end else begin
            if (noisy) begin
                n_val = 10'($urandom_range(0, 1023));
                a_val = 7'($urandom_range(0, 127));
                noisy_period = 1'b1;
            end
            first_after_rst = 1'b0;
            k++;
        end
        @(negedge clk);
        if (noisy_period) tag = "R5";
        else if (first_after_rst) tag = "R1";
        else if (cur_n <= 1) tag = "R8";
        else tag = "R2";
        check(fv == exp_fv(k), {tag, " fv"}, fv, exp_fv(k));
        if (noisy_period) tag = "R5";
        else if (cur_a == 0) tag = "R6";
        else if (cur_a >= eff_len(cur_n)) tag = "R7";
        else if (k < cur_a) tag = "R3";
        else tag = "R4";
        check(mc == exp_mc(k, cur_a), {tag, " mc"}, mc, exp_mc(k, cur_a));
    endtask

    task automatic run(input int nn, input int aa, input int cycles, input bit noisy);
        int target;
        target = reloads + cycles;
        while (reloads < target) step(nn, aa, noisy);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        started = 1'b0;
        @(negedge clk);
        check(mc == 1'b0, "R1 mc in reset", mc, 0);
        check(fv == 1'b0, "R1 fv in reset", fv, 0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(mc == 1'b0, "R1 mc in reset", mc, 0);
        check(fv == 1'b0, "R1 fv in reset", fv, 0);
        rst_n = 1'b1;

        // Directed corners.
        run(5, 2, 3, 1'b0);      // R3 R4
        run(6, 0, 2, 1'b0);      // R6
        run(4, 4, 2, 1'b0);      // R7 with A == N
        run(3, 9, 2, 1'b0);      // R7 with A > N
        run(1, 0, 3, 1'b0);      // R8
        run(0, 0, 3, 1'b0);      // R8
        run(1, 5, 2, 1'b0);      // R8 with high modulus
        run(2, 1, 3, 1'b0);      // shortest split cycle
        run(1023, 127, 2, 1'b0); // widest values
        run(8, 3, 4, 1'b1);      // R5 noisy inputs mid-cycle

        do_reset();              // R1 mid-run reset
        run(7, 2, 3, 1'b0);

        // Constrained random cycles, some with mid-cycle noise.
        for (int i = 0; i < 150; i++) begin
            int nn, aa;
            nn = (i % 10 == 0) ? $urandom_range(0, 300) : $urandom_range(0, 40);
            aa = $urandom_range(0, (nn + 3 > 127) ? 127 : nn + 3);
            run(nn, aa, $urandom_range(1, 3), $urandom_range(0, 1) == 1);
            if (i == 75) do_reset();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule